// File: doc/BRIEF.md
# Actuator DAC Ramp Sequencer

This block produces a staircase of DAC codes that takes an actuator amplifier from zero up to full scale after a start request. Each symbol-rate tick adds one step to the code, and a single-cycle strobe marks the new code for the DAC serial link. The default build climbs 1562 steps of one code each, which is about 3.2 mV per step on a 5 V scale. When the code reaches the top step, the ramp is complete and a done level is raised.

While the ramp runs, the block also watches it. A cycle budget covers the whole ramp, and a ramp that overruns the budget sets a slow-ramp flag. A position-feedback monitor outside the block pulses an acknowledge each time it sees the actuator move. Each acknowledge records the code in force at that moment as the confirmed code. If too many ticks pass without an acknowledge, a stuck-feedback flag is set. When the monitor finds that a finished ramp fell short, it pulses a re-trigger. The ramp then resumes from the confirmed code instead of starting again from zero. Both flags stay set until a clear pulse arrives.

The sequencer has three states. IDLE holds after reset. RAMP steps on each tick. DONE holds the final code. The transitions are:
- IDLE→RAMP on start.
- RAMP→DONE on the tick that reaches the top step.
- DONE→RAMP on start, which begins again from zero.
- DONE→RAMP on re-trigger, which resumes, but only when the confirmed code is below the top step.

Top module: `act_ramp_seq`

## Requirements
- R1: After synchronous reset, the block is in IDLE: code 0, strobe low, done low, both flags low.
- R2: A start in IDLE or DONE begins a ramp from code 0. In RAMP, each tick raises the code by exactly 1 and raises the strobe for one cycle.
- R3: The tick that brings the code to STEPS enters DONE and raises done. Ticks in IDLE or DONE give no strobe and leave the code unchanged.
- R4: A start that arrives during RAMP is ignored, and the staircase goes on without a break.
- R5: An acknowledge in RAMP or DONE records the current code as confirmed. A re-trigger in DONE reloads the confirmed code, so the next tick emits confirmed+1, and done falls.
- R6: A re-trigger in IDLE has no effect. A re-trigger in DONE when the confirmed code equals STEPS also has no effect, and the block stays in DONE.
- R7: The slow flag is set once the block has spent TIMEOUT_CYC cycles in RAMP since the last start. Cycles spent in DONE do not count.
- R8: The stuck flag is set on the STALL_TICKS-th tick in RAMP that arrives without an acknowledge. Each acknowledge, and each entry into RAMP, restarts that count.
- R9: Both flags are sticky. A clear pulse drops them unless a set condition occurs in the same cycle.
- R10: The code never exceeds STEPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a ramp from zero |
| tick | input | 1 | Symbol-rate step enable |
| retrig | input | 1 | Resume request from the feedback monitor |
| fb_ack | input | 1 | Feedback saw movement; confirm the current code |
| err_clr | input | 1 | Clear both error flags |
| dac_code | output | CODE_W | Current DAC code |
| dac_valid | output | 1 | One-cycle strobe marking a new code |
| done | output | 1 | Ramp complete (DONE state) |
| err_slow | output | 1 | Sticky ramp-overrun flag |
| err_stuck | output | 1 | Sticky feedback-stall flag |

## Verification
The bench targets the cases where the staircase could break:
- A start in the middle of a ramp. A design that honoured it would drop back to code 1.
- A re-trigger. A design that ignored the confirmed code would restart from zero or skip codes.
- A re-trigger while IDLE, or once the top step is already confirmed. A wrong design would emit strobes that the scoreboard does not expect, or run past the top step.

The bench also drives the stall count to exactly one tick short of the limit and then to the limit, which catches an off-by-one in the stuck count. It runs a slow ramp, checks that the slow flag stays set, and then clears it, which exposes flags that are not sticky or that clear themselves.

// File: rtl/act_ramp_pkg.sv
package act_ramp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_DONE = 2'd2
    } ramp_state_t;
endpackage

// File: rtl/ramp_step_fsm.sv
module ramp_step_fsm
    import act_ramp_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int STEPS  = 1562
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  logic              retrig,
    input  logic              fb_ack,
    output logic [CODE_W-1:0] code,
    output logic              valid,
    output logic              done,
    output logic              in_ramp,
    output logic              ramp_entry
);
    localparam logic [CODE_W-1:0] TOP      = CODE_W'(STEPS);
    localparam logic [CODE_W-1:0] TOP_LESS = CODE_W'(STEPS - 1);

    ramp_state_t       state, state_n;
    logic [CODE_W-1:0] code_q, conf_q;
    logic              valid_q;
    logic              resume_ok;

    assign resume_ok = retrig && (conf_q != TOP);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start) state_n = ST_RAMP;
            ST_RAMP: if (tick && code_q == TOP_LESS) state_n = ST_DONE;
            ST_DONE: if (start || resume_ok) state_n = ST_RAMP;
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            conf_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        code_q <= '0;
                        conf_q <= '0;
                    end
                end
                ST_RAMP: begin
                    if (fb_ack) conf_q <= code_q;
                    if (tick) begin
                        code_q  <= code_q + CODE_W'(1);
                        valid_q <= 1'b1;
                    end
                end
                ST_DONE: begin
                    if (start) begin
                        code_q <= '0;
                        conf_q <= '0;
                    end else if (resume_ok) begin
                        code_q <= conf_q;
                    end else if (fb_ack) begin
                        conf_q <= code_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign code       = code_q;
    assign valid      = valid_q;
    assign done       = (state == ST_DONE);
    assign in_ramp    = (state == ST_RAMP);
    assign ramp_entry = (state != ST_RAMP) && (state_n == ST_RAMP);

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (code_q == $past(code_q) + CODE_W'(1)));
    // R10
    code_max_chk: assert property (@(posedge clk) disable iff (rst)
        code_q <= TOP);
    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !start && !retrig) |=> $stable(code_q));
endmodule

// File: rtl/ramp_watch.sv
module ramp_watch #(
    parameter int TIMEOUT_CYC = 125000,
    parameter int STALL_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic in_ramp,
    input  logic ramp_entry,
    input  logic start,
    input  logic tick,
    input  logic fb_ack,
    input  logic err_clr,
    output logic err_slow,
    output logic err_stuck
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int SW = $clog2(STALL_TICKS + 1);

    logic [TW-1:0] elapsed;
    logic [SW-1:0] quiet;
    logic          fresh, slow_hit, stuck_hit;

    assign fresh     = ramp_entry && start;
    assign slow_hit  = in_ramp && (elapsed == TW'(TIMEOUT_CYC - 1));
    assign stuck_hit = in_ramp && tick && !fb_ack && (quiet == SW'(STALL_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || fresh)                                     elapsed <= '0;
        else if (in_ramp && elapsed != TW'(TIMEOUT_CYC))      elapsed <= elapsed + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || ramp_entry || fb_ack)                      quiet <= '0;
        else if (in_ramp && tick && quiet != SW'(STALL_TICKS)) quiet <= quiet + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_slow  <= 1'b0;
            err_stuck <= 1'b0;
        end else begin
            if (slow_hit)     err_slow <= 1'b1;
            else if (err_clr) err_slow <= 1'b0;
            if (stuck_hit)    err_stuck <= 1'b1;
            else if (err_clr) err_stuck <= 1'b0;
        end
    end

    // R9
    slow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_slow && !err_clr) |=> err_slow);
    // R9
    stuck_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_stuck && !err_clr) |=> err_stuck);
    // R8
    stuck_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_stuck) |-> $past(in_ramp && tick));
endmodule

// File: rtl/act_ramp_seq.sv
module act_ramp_seq #(
    parameter int CODE_W      = 12,
    parameter int STEPS       = 1562,
    parameter int TIMEOUT_CYC = 125000,
    parameter int STALL_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  logic              retrig,
    input  logic              fb_ack,
    input  logic              err_clr,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_valid,
    output logic              done,
    output logic              err_slow,
    output logic              err_stuck
);
    logic in_ramp, ramp_entry;

    ramp_step_fsm #(.CODE_W(CODE_W), .STEPS(STEPS)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .retrig(retrig),
        .fb_ack(fb_ack), .code(dac_code), .valid(dac_valid), .done(done),
        .in_ramp(in_ramp), .ramp_entry(ramp_entry)
    );

    ramp_watch #(.TIMEOUT_CYC(TIMEOUT_CYC), .STALL_TICKS(STALL_TICKS)) u_watch (
        .clk(clk), .rst(rst), .in_ramp(in_ramp), .ramp_entry(ramp_entry),
        .start(start), .tick(tick), .fb_ack(fb_ack), .err_clr(err_clr),
        .err_slow(err_slow), .err_stuck(err_stuck)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!dac_valid && !done && !err_slow && !err_stuck));
endmodule

// File: tb/act_ramp_seq_tb_top.sv
module act_ramp_seq_tb_top;
    localparam int CODE_W = 12;
    localparam int STEPS  = 16;
    localparam int TOUT   = 200;
    localparam int STALL  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, tick = 0, retrig = 0, fb_ack = 0, err_clr = 0;
    logic [CODE_W-1:0] dac_code;
    logic dac_valid, done, err_slow, err_stuck;

    int total = 0, bad = 0;
    int exp_code = 0;
    int exp_q[$];
    bit finished = 0;

    always #4 clk = ~clk;

    act_ramp_seq #(.CODE_W(CODE_W), .STEPS(STEPS), .TIMEOUT_CYC(TOUT),
                   .STALL_TICKS(STALL)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .retrig(retrig),
        .fb_ack(fb_ack), .err_clr(err_clr), .dac_code(dac_code),
        .dac_valid(dac_valid), .done(done), .err_slow(err_slow),
        .err_stuck(err_stuck)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop expected codes as strobes appear
    always @(negedge clk) begin
        if (!rst && dac_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected strobe", int'(dac_code), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(dac_code) == e, "R2 step code", int'(dac_code), e);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: push expected item when a step is due
    task automatic do_tick(input bit step);
        if (step) begin
            exp_code++;
            exp_q.push_back(exp_code);
        end
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask
    task automatic do_ack();
        @(negedge clk); fb_ack = 1;
        @(negedge clk); fb_ack = 0;
    endtask
    task automatic do_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask
    task automatic do_retrig();
        @(negedge clk); retrig = 1;
        @(negedge clk); retrig = 0;
    endtask
    task automatic do_clr();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst = 0;
        cyc(1);
        // R1 reset state
        check(dac_code == 0 && !dac_valid, "R1 code/strobe", int'(dac_code), 0);
        check(!done && !err_slow && !err_stuck, "R1 flags", int'({done, err_slow, err_stuck}), 0);

        // R6 retrig in IDLE ignored; tick in IDLE no strobe
        do_retrig();
        do_tick(0);
        cyc(2);
        check(!done && dac_code == 0, "R6 idle retrig", int'(dac_code), 0);

        // R2/R4/R5 main ramp, acks stop after code 10, mid-ramp start ignored
        exp_code = 0;
        do_start();
        for (int i = 1; i <= STEPS; i++) begin
            do_tick(1);
            if (i <= 10) do_ack();
            if (i == 5) do_start();
            cyc(1);
        end
        cyc(1);
        check(done == 1, "R3 done raised", int'(done), 1);
        check(int'(dac_code) == STEPS, "R3 final code", int'(dac_code), STEPS);
        check(!err_slow && !err_stuck, "R7 no flags on fast ramp", int'({err_slow, err_stuck}), 0);

        // R3 tick in DONE ignored
        do_tick(0);
        cyc(2);
        check(int'(dac_code) == STEPS && done, "R3 done hold", int'(dac_code), STEPS);

        // R5 resume from confirmed code 10
        exp_code = 10;
        do_retrig();
        check(!done, "R5 done falls on resume", int'(done), 0);
        check(dac_code == 10, "R5 reload confirmed", int'(dac_code), 10);
        for (int i = 0; i < STEPS - 10; i++) begin
            do_tick(1);
            cyc(1);
        end
        cyc(1);
        check(done == 1, "R5 resumed ramp completes", int'(done), 1);

        // R6 retrig with top step confirmed: stays DONE
        do_ack();
        do_retrig();
        do_tick(0);
        cyc(2);
        check(done && int'(dac_code) == STEPS, "R6 top confirmed retrig", int'(done), 1);

        // R8 stall count boundary
        exp_code = 0;
        do_start();
        for (int i = 1; i < STALL; i++) begin
            do_tick(1);
        end
        check(!err_stuck, "R8 one short of stall", int'(err_stuck), 0);
        do_tick(1);
        check(err_stuck, "R8 stall reached", int'(err_stuck), 1);
        for (int i = STALL + 1; i <= STEPS; i++) begin
            do_tick(1);
            do_ack();
        end
        cyc(1);
        check(err_stuck && done, "R9 stuck sticky", int'(err_stuck), 1);
        do_clr();
        check(!err_stuck, "R9 stuck cleared", int'(err_stuck), 0);

        // R7 slow ramp
        exp_code = 0;
        do_start();
        for (int i = 1; i <= STEPS; i++) begin
            do_tick(1);
            do_ack();
            cyc(16);
            if (i == 5) check(!err_slow, "R7 within budget", int'(err_slow), 0);
        end
        cyc(1);
        check(err_slow && done, "R7 slow flag set", int'(err_slow), 1);
        check(!err_stuck, "R8 acks keep stuck low", int'(err_stuck), 0);
        cyc(20);
        check(err_slow, "R9 slow sticky in DONE", int'(err_slow), 1);
        do_clr();
        check(!err_slow, "R9 slow cleared", int'(err_slow), 0);

        cyc(3);
        check(exp_q.size() == 0, "R2 all codes seen", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule